// File: doc/BRIEF.md
# Shared-Clock PWM Timer Bank

A bank of pulse-width outputs that all run from one prescaled tick and one free-running 16-bit counter. A source-select bit picks one of two single-cycle clock-enable inputs as the base rate. An 8-bit divisor then turns that rate into the common timer tick. Each channel runs either with a 65536-tick period or a 256-tick period. The 16-bit value written to a channel gives the number of ticks per period during which its output is driven low. For the rest of the period the output is high.

Configuration is taken as a set. The source select, divisor, per-channel mode bits and enabled-channel count are captured together on one update strobe, and that strobe re-initializes the whole bank. Channel values are written separately, one strobe per channel. A written value waits in a shadow register and takes effect at the channel's next period boundary. Because every channel compares against the same counter, channels in the same mode fall in the same cycle. After a configuration update, an output only begins at the first counter roll-over, so it can start up to one full period late.

The sequencer has three states. In SEQ_IDLE the bank is unconfigured and the counter is held. SEQ_INIT lasts one cycle and clears the counter, the prescaler and all channel values. In SEQ_RUN the bank counts. The transitions are: IDLE to INIT on a configuration strobe, INIT to RUN, INIT to INIT on a repeated strobe, and RUN to INIT on a strobe. Each channel has three states. CH_OFF means disabled, CH_WAIT means enabled and waiting for the first period boundary, and CH_ACTIVE means generating the waveform. The transitions are: any state to CH_WAIT or CH_OFF during SEQ_INIT, depending on the enable, and CH_WAIT to CH_ACTIVE at the channel's first period boundary.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset every output is high, and the counter does not advance until the first configuration strobe.
- R2: The tick fires once every D enables of the selected base input. `cfg_src_sel`=0 selects `base_en_a` and 1 selects `base_en_b`. D equals `cfg_divisor`, except that a divisor of 0 gives D=256.
- R3: A channel whose mode bit is 0 has a 65536-tick period. It is low for the first V ticks of each period and high for the rest, where V is the full 16-bit value. V=0 keeps the output permanently high.
- R4: A channel whose mode bit is 1 has a 256-tick period. It is low for the first V[15:8] ticks of each period, and bits [7:0] of the value have no effect.
- R5: All channels compare against one shared counter. A falling edge happens only at a period boundary, so active channels in the same mode fall in the same cycle.
- R6: After a configuration strobe, an enabled channel stays high until the first period boundary of its own mode. It then starts its low phase.
- R7: A configuration strobe captures source, divisor, modes and count, and clears the counter, the prescaler and every channel value to 0. All outputs are high in the cycle after the init cycle.
- R8: A value takes effect only with that channel's `val_update` bit. It is applied at the channel's next period boundary and leaves the current period unchanged. A value written in the boundary cycle itself is applied at once.
- R9: Channels with index not below `cfg_num_on` are disabled. They drive high and ignore value writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free reset, sampled on the clock |
| base_en_a | input | 1 | Base clock enable, source 0 |
| base_en_b | input | 1 | Base clock enable, source 1 |
| cfg_update | input | 1 | Configuration capture and re-initialize strobe |
| cfg_src_sel | input | 1 | Base source select (0 = a, 1 = b) |
| cfg_divisor | input | 8 | Tick divisor, 0 means 256 |
| cfg_mode | input | NUM_CH | Per-channel mode bit: 0 = 16-bit, 1 = 8-bit |
| cfg_num_on | input | NUM_W | Number of enabled channels, counted from channel 0 |
| val_update | input | NUM_CH | Per-channel value write strobe |
| val_data | input | NUM_CH*16 | Per-channel value, channel i in bits [16i+15:16i] |
| pwm_out | output | NUM_CH | Pulse-width outputs |

## Verification
The assertions assume that the base enables are plain single-cycle qualifiers, and that the configuration and value buses are valid in every cycle in which their strobe is high. They also assume reset is held low from time zero until the stimulus starts. The bench drives every strobe for exactly one cycle, away from the active edge. It ties source a high, toggles source b every cycle, and writes values drawn from a fixed seed at random phases inside the 8-bit period. Long waits are bounded by known roll-over points, so each measured window covers whole periods.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_INIT = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        CH_OFF    = 2'd0,
        CH_WAIT   = 2'd1,
        CH_ACTIVE = 2'd2
    } ch_state_t;

    typedef enum logic {
        MODE_W16 = 1'b0,
        MODE_W8  = 1'b1
    } pwm_mode_t;

endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DIV_W  = 8,
    parameter int NUM_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_update,
    input  logic              cfg_src_sel,
    input  logic [DIV_W-1:0]  cfg_divisor,
    input  logic [NUM_CH-1:0] cfg_mode,
    input  logic [NUM_W-1:0]  cfg_num_on,
    output logic              init_o,
    output logic              run_o,
    output logic              src_sel_o,
    output logic [DIV_W-1:0]  divisor_o,
    output logic [NUM_CH-1:0] mode_o,
    output logic [NUM_CH-1:0] ch_en_o
);

    seq_state_t state_q, state_d;
    logic [NUM_W-1:0] num_on_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: state_d = cfg_update ? SEQ_INIT : SEQ_IDLE;
            SEQ_INIT: state_d = cfg_update ? SEQ_INIT : SEQ_RUN;
            SEQ_RUN:  state_d = cfg_update ? SEQ_INIT : SEQ_RUN;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    // configuration capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_sel_o <= 1'b0;
            divisor_o <= '0;
            mode_o    <= '0;
            num_on_q  <= '0;
        end else if (cfg_update) begin
            src_sel_o <= cfg_src_sel;
            divisor_o <= cfg_divisor;
            mode_o    <= cfg_mode;
            num_on_q  <= cfg_num_on;
        end
    end

    // outputs
    always_comb begin
        init_o = 1'b0;
        run_o  = 1'b0;
        unique case (state_q)
            SEQ_INIT: init_o = 1'b1;
            SEQ_RUN:  run_o  = 1'b1;
            default: begin
                init_o = 1'b0;
                run_o  = 1'b0;
            end
        endcase
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_en
        assign ch_en_o[i] = (int'(num_on_q) > i);
    end

    // R7: one init cycle, then running unless another strobe arrives
    a_r7_init_to_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_INIT && !cfg_update) |=> run_o);

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
    parameter int CNT_W = 16,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             run,
    input  logic             base_en_a,
    input  logic             base_en_b,
    input  logic             src_sel,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick_o,
    output logic [CNT_W-1:0] cnt_o
);

    logic [DIV_W-1:0] pre_q;
    logic [DIV_W-1:0] div_last;
    logic             base_en;
    logic             at_last;

    // divisor 0 wraps to the all-ones terminal count: divide by 2**DIV_W
    assign div_last = divisor - DIV_W'(1);
    assign base_en  = src_sel ? base_en_b : base_en_a;
    assign at_last  = (pre_q == div_last);
    assign tick_o   = run && base_en && at_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_o <= '0;
        end else if (init) begin
            pre_q <= '0;
            cnt_o <= '0;
        end else if (run && base_en) begin
            if (at_last) begin
                pre_q <= '0;
                cnt_o <= cnt_o + CNT_W'(1);
            end else begin
                pre_q <= pre_q + DIV_W'(1);
            end
        end
    end

    // R2: prescaler never passes its terminal count
    a_r2_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pre_q <= div_last));

    // R1: counter holds while not running
    a_r1_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !init) |=> $stable(cnt_o));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LOW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             enabled,
    input  pwm_mode_t        mode,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic             upd,
    input  logic [CNT_W-1:0] upd_val,
    output logic             pwm_o
);

    ch_state_t        st_q, st_d;
    logic [CNT_W-1:0] act_q;
    logic [CNT_W-1:0] shadow_q;
    logic             pend_q;
    logic             at_end;
    logic             wrap;
    logic             below;

    always_comb begin
        at_end = 1'b0;
        below  = 1'b0;
        unique case (mode)
            MODE_W8: begin
                at_end = &cnt[LOW_W-1:0];
                below  = cnt[LOW_W-1:0] < act_q[CNT_W-1 -: LOW_W];
            end
            MODE_W16: begin
                at_end = &cnt;
                below  = cnt < act_q;
            end
            default: begin
                at_end = 1'b0;
                below  = 1'b0;
            end
        endcase
    end

    assign wrap = tick && at_end;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= CH_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        if (init) begin
            st_d = enabled ? CH_WAIT : CH_OFF;
        end else begin
            unique case (st_q)
                CH_OFF:    st_d = CH_OFF;
                CH_WAIT:   st_d = wrap ? CH_ACTIVE : CH_WAIT;
                CH_ACTIVE: st_d = CH_ACTIVE;
                default:   st_d = CH_OFF;
            endcase
        end
    end

    // value path: shadow until the channel's period boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= '0;
            shadow_q <= '0;
            pend_q   <= 1'b0;
        end else if (init) begin
            act_q    <= '0;
            shadow_q <= '0;
            pend_q   <= 1'b0;
        end else if (st_q != CH_OFF) begin
            if (wrap) begin
                act_q  <= upd ? upd_val : (pend_q ? shadow_q : act_q);
                pend_q <= 1'b0;
            end else if (upd) begin
                shadow_q <= upd_val;
                pend_q   <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        pwm_o = 1'b1;
        if (!init) begin
            unique case (st_q)
                CH_ACTIVE: pwm_o = !below;
                default:   pwm_o = 1'b1;
            endcase
        end
    end

    // R8: active value only moves at a period boundary or re-init
    a_r8_hold_between_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && !init) |=> $stable(act_q));

    // R3: zero low count never drives low
    a_r3_zero_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_ACTIVE && act_q == '0) |-> pwm_o);

    // R9: a disabled channel keeps no value
    a_r9_off_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_OFF) |-> (act_q == '0 && !pend_q));

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16,
    parameter int LOW_W  = 8,
    parameter int DIV_W  = 8,
    parameter int NUM_W  = $clog2(NUM_CH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    base_en_a,
    input  logic                    base_en_b,
    input  logic                    cfg_update,
    input  logic                    cfg_src_sel,
    input  logic [DIV_W-1:0]        cfg_divisor,
    input  logic [NUM_CH-1:0]       cfg_mode,
    input  logic [NUM_W-1:0]        cfg_num_on,
    input  logic [NUM_CH-1:0]       val_update,
    input  logic [NUM_CH*CNT_W-1:0] val_data,
    output logic [NUM_CH-1:0]       pwm_out
);

    logic              init;
    logic              run;
    logic              src_sel_q;
    logic [DIV_W-1:0]  div_q;
    logic [NUM_CH-1:0] mode_q;
    logic [NUM_CH-1:0] ch_en;
    logic              tick;
    logic [CNT_W-1:0]  cnt;

    pwm_ctrl #(
        .NUM_CH (NUM_CH),
        .DIV_W  (DIV_W),
        .NUM_W  (NUM_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_update  (cfg_update),
        .cfg_src_sel (cfg_src_sel),
        .cfg_divisor (cfg_divisor),
        .cfg_mode    (cfg_mode),
        .cfg_num_on  (cfg_num_on),
        .init_o      (init),
        .run_o       (run),
        .src_sel_o   (src_sel_q),
        .divisor_o   (div_q),
        .mode_o      (mode_q),
        .ch_en_o     (ch_en)
    );

    pwm_tick_gen #(
        .CNT_W (CNT_W),
        .DIV_W (DIV_W)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (init),
        .run       (run),
        .base_en_a (base_en_a),
        .base_en_b (base_en_b),
        .src_sel   (src_sel_q),
        .divisor   (div_q),
        .tick_o    (tick),
        .cnt_o     (cnt)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwm_channel #(
            .CNT_W (CNT_W),
            .LOW_W (LOW_W)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .init    (init),
            .enabled (ch_en[i]),
            .mode    (pwm_mode_t'(mode_q[i])),
            .tick    (tick),
            .cnt     (cnt),
            .upd     (val_update[i]),
            .upd_val (val_data[i*CNT_W +: CNT_W]),
            .pwm_o   (pwm_out[i])
        );

        // R5: falling edges only where the shared counter starts a period
        a_r5_fall_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pwm_out[i]) |->
                ((mode_q[i] == MODE_W8) ? (cnt[LOW_W-1:0] == '0) : (cnt == '0)));

        // R9: disabled channels stay high
        a_r9_disabled_high: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[i] |-> pwm_out[i]);
    end

    // R7: re-init leaves every output high
    a_r7_reinit_high: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (&pwm_out));

endmodule

// File: tb/test_pwm_timer_bank.sv
module test_pwm_timer_bank;

    localparam int NCH = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            base_en_a = 1'b1;
    logic            base_en_b = 1'b0;
    logic            cfg_update = 1'b0;
    logic            cfg_src_sel = 1'b0;
    logic [7:0]      cfg_divisor = '0;
    logic [NCH-1:0]  cfg_mode = '0;
    logic [2:0]      cfg_num_on = '0;
    logic [NCH-1:0]  val_update = '0;
    logic [NCH*16-1:0] val_data = '0;
    logic [NCH-1:0]  pwm_out;

    int checks = 0;
    int failures = 0;
    int lows [NCH];

    always #2 clk = ~clk;

    always @(negedge clk) base_en_b <= ~base_en_b;

    pwm_timer_bank i_pwm_timer_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_en_a   (base_en_a),
        .base_en_b   (base_en_b),
        .cfg_update  (cfg_update),
        .cfg_src_sel (cfg_src_sel),
        .cfg_divisor (cfg_divisor),
        .cfg_mode    (cfg_mode),
        .cfg_num_on  (cfg_num_on),
        .val_update  (val_update),
        .val_data    (val_data),
        .pwm_out     (pwm_out)
    );

    function automatic int exp_low8(input logic [15:0] v);
        return int'(v[15:8]);
    endfunction

    function automatic int exp_low_cycles(input int low_ticks, input int div, input int en_gap);
        int d = (div == 0) ? 256 : div;
        return low_ticks * d * en_gap;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_cfg(input bit src, input int div, input logic [NCH-1:0] mode, input int num);
        @(negedge clk);
        cfg_src_sel = src;
        cfg_divisor = 8'(div);
        cfg_mode    = mode;
        cfg_num_on  = 3'(num);
        cfg_update  = 1'b1;
        @(negedge clk);
        cfg_update  = 1'b0;
    endtask

    task automatic write_val(input int ch, input logic [15:0] v);
        @(negedge clk);
        val_data[ch*16 +: 16] = v;
        val_update[ch] = 1'b1;
        @(negedge clk);
        val_update = '0;
    endtask

    task automatic count_lows(input int n);
        for (int c = 0; c < NCH; c++) lows[c] = 0;
        repeat (n) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) if (!pwm_out[c]) lows[c]++;
        end
    endtask

    task automatic wait_fall(input int ch, output logic [NCH-1:0] prev_v);
        logic [NCH-1:0] p;
        p = pwm_out;
        forever begin
            @(negedge clk);
            if (p[ch] && !pwm_out[ch]) break;
            p = pwm_out;
        end
        prev_v = p;
    endtask

    task automatic low_width(input int ch, output int w);
        w = 0;
        while (!pwm_out[ch]) begin
            w++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [NCH-1:0] pv;
        int w;
        void'($urandom(32'd4242));

        repeat (5) @(negedge clk);
        check(pwm_out == 4'hF, "R1 reset outputs high", int'(pwm_out), 15);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(pwm_out == 4'hF, "R1 idle outputs high", int'(pwm_out), 15);

        // ch0,ch1,ch3 8-bit; ch2 16-bit; three enabled; tick every cycle
        do_cfg(1'b0, 1, 4'b1011, 3);
        write_val(0, 16'h4000);
        write_val(1, 16'h80FF);
        write_val(2, 16'h0100);
        write_val(3, 16'h8000);
        repeat (180) @(negedge clk);
        check(pwm_out == 4'hF, "R6 high before first wrap", int'(pwm_out), 15);
        repeat (80) @(negedge clk);
        check(pwm_out[1:0] == 2'b00, "R6 low phase after first wrap", int'(pwm_out[1:0]), 0);

        count_lows(256);
        check(lows[0] == exp_low8(16'h4000), "R4 ch0 low ticks", lows[0], exp_low8(16'h4000));
        check(lows[1] == exp_low8(16'h80FF), "R4 low byte ignored", lows[1], exp_low8(16'h80FF));
        check(lows[3] == 0, "R9 disabled ignores write", lows[3], 0);
        check(lows[2] == 0, "R6 16-bit channel still waiting", lows[2], 0);

        // R8: mid-period write does not disturb the running period
        wait_fall(1, pv);
        repeat (100) @(negedge clk);
        write_val(0, 16'hC000);
        count_lows(100);
        check(lows[0] == 0, "R8 current period unchanged", lows[0], 0);
        repeat (100) @(negedge clk);
        count_lows(256);
        check(lows[0] == exp_low8(16'hC000), "R8 applied next period", lows[0], exp_low8(16'hC000));

        write_val(0, 16'h0000);
        repeat (300) @(negedge clk);
        count_lows(256);
        check(lows[0] == 0, "R3 zero value always high", lows[0], 0);

        write_val(0, 16'hFF00);
        repeat (300) @(negedge clk);
        count_lows(256);
        check(lows[0] == 255, "R4 maximum 8-bit low", lows[0], 255);

        for (int k = 0; k < 8; k++) begin
            logic [15:0] v;
            v = 16'($urandom);
            repeat (int'($urandom % 256)) @(negedge clk);
            write_val(0, v);
            repeat (300) @(negedge clk);
            count_lows(256);
            check(lows[0] == exp_low8(v), "R4 random value", lows[0], exp_low8(v));
        end

        write_val(0, 16'h4000);
        wait_fall(2, pv);
        check(pv[0] && !pwm_out[0], "R5 ch0 falls with ch2", int'(pwm_out[0]), 0);
        check(pv[1] && !pwm_out[1], "R5 ch1 falls with ch2", int'(pwm_out[1]), 0);
        low_width(2, w);
        check(w == 256, "R3 16-bit low width", w, 256);

        // source b, divisor 3, two enabled
        do_cfg(1'b1, 3, 4'b0001, 2);
        @(negedge clk);
        check(pwm_out == 4'hF, "R7 outputs high after re-init", int'(pwm_out), 15);
        write_val(0, 16'h4000);
        write_val(2, 16'h8000);
        repeat (1700) @(negedge clk);
        count_lows(1536);
        check(lows[0] == exp_low_cycles(64, 3, 2), "R2 source b divide by 3", lows[0],
              exp_low_cycles(64, 3, 2));
        check(lows[1] == 0, "R7 values cleared by re-init", lows[1], 0);
        check(lows[2] == 0, "R9 disabled after count shrinks", lows[2], 0);

        // divisor 0 means 256
        do_cfg(1'b0, 0, 4'b0001, 1);
        write_val(0, 16'h0100);
        wait_fall(0, pv);
        low_width(0, w);
        check(w == exp_low_cycles(1, 0, 1), "R2 divisor zero", w, exp_low_cycles(1, 0, 1));

        finish_run();
    end

endmodule